// File: doc/BRIEF.md
# Aging Priority-Raise Command Arbiter

This block chooses the next memory command to issue from a small pool of waiting commands. Each command carries a service class (class 1 or class 2) and the pool records the order in which commands arrived. In normal operation class 1 work goes first and, inside a class, the longest-waiting command goes first. Left alone, that rule can starve class 2 work or leave an old command waiting forever.

Three programmable starvation timers work against that. One timer serves class 1, one serves class 2, and one serves the single longest-waiting command. Each timer counts in steps of 16 clock cycles. When a timer runs out, its group is briefly promoted for one arbitration decision. The timer then reloads and starts counting again.

A 32-bit configuration word holds the three 8-bit timer settings and is reached through a simple read/write register port. Commands are accepted through an enqueue handshake. A registered grant reports the pool slot that was issued whenever the downstream side is ready.

Top module: `cmd_age_arbiter`

## Requirements
- R1: The configuration word holds the oldest-command setting in bits 7:0, the class 2 setting in bits 15:8 and the class 1 setting in bits 23:16. A write stores all three fields. A read pulse returns the word on `reg_rdata` one clock later.
- R2: Bits 31:24 of the configuration word always read as zero, and writes to them have no effect.
- R3: After reset all three settings are 0xFF, the pool is empty, `enq_ready` is 1 and `grant_valid` is 0.
- R4: With no promotion active, any class 1 command (`enq_cls`=0) wins over every class 2 command (`enq_cls`=1). Inside a class, the command that arrived earliest wins.
- R5: A timer with setting N must count N×16 cycles in which it is eligible before its promotion becomes active. Writing the configuration word reloads every timer at once with its new setting ×16.
- R6: While the oldest-command promotion is active, the next grant goes to the earliest-arrived command of either class.
- R7: While the class 1 promotion is active, the next grant goes to the earliest class 1 command. While the class 2 promotion is active, the next grant goes to the earliest class 2 command, even if class 1 commands are waiting.
- R8: When several promotions are active together, the oldest-command promotion ranks first, class 1 second and class 2 third. Only the promotion that decided a grant is used up; the others stay active for the following decisions.
- R9: A setting of 0 disables that timer, so it never promotes anything.
- R10: When `deq_ready` is high and at least one command is waiting, one command is removed at the clock edge. On the next cycle `grant_valid` is 1 and `grant_idx` gives its slot. A new command takes the lowest free slot. `enq_ready` is 0 while all slots are full, and an enqueue attempted then is dropped.
- R11: A timer counts only while at least one command it could promote is waiting. Otherwise it holds at its reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer a new command |
| enq_cls | input | 1 | Class of the offered command: 0 = class 1, 1 = class 2 |
| enq_ready | output | 1 | A free slot exists |
| deq_ready | input | 1 | Downstream can take a command this cycle |
| grant_valid | output | 1 | A command was granted at the last edge |
| grant_idx | output | 3 | Slot of the granted command |
| reg_wr | input | 1 | Write strobe for the configuration word |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
Several promotions can be active in the same cycle as an arbitration decision. This is also when the rule that only the deciding promotion is used up comes into play. The bench sets up this case by setting all three timers to one step, filling the pool with a mix of classes and keeping `deq_ready` low long enough for every timer to expire. It then grants on four back-to-back cycles. The order is judged against a model worked out by hand: oldest command first, then the earliest class 1 command, then the earliest class 2 command, then normal ordering for the remaining slot. That order differs from the one normal ordering would give.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;
  localparam logic [7:0] FIELD_RST = 8'hFF;
  localparam int N_TIMERS = 3;
  // timer slots: 0 = oldest command, 1 = class 1, 2 = class 2
  localparam int T_OLD = 0;
  localparam int T_C1  = 1;
  localparam int T_C2  = 2;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
  parameter int FIELD_W = 8,
  localparam int REG_W = 4 * FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic                  reg_rd,
  output logic [REG_W-1:0]      reg_rdata,
  output logic [2:0][FIELD_W-1:0] fld_cur,
  output logic [2:0][FIELD_W-1:0] fld_new
);
  import cmd_arb_pkg::*;

  logic [3*FIELD_W-1:0] cfg_q;
  logic unused_rsvd;

  assign unused_rsvd = ^reg_wdata[REG_W-1:3*FIELD_W];

  // field placement: oldest low byte, class 2 middle, class 1 upper
  assign fld_cur[T_OLD] = cfg_q[FIELD_W-1:0];
  assign fld_cur[T_C2]  = cfg_q[2*FIELD_W-1:FIELD_W];
  assign fld_cur[T_C1]  = cfg_q[3*FIELD_W-1:2*FIELD_W];
  assign fld_new[T_OLD] = reg_wdata[FIELD_W-1:0];
  assign fld_new[T_C2]  = reg_wdata[2*FIELD_W-1:FIELD_W];
  assign fld_new[T_C1]  = reg_wdata[3*FIELD_W-1:2*FIELD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= {3{FIELD_W'(FIELD_RST)}};
      reg_rdata <= '0;
    end else begin
      if (reg_wr) cfg_q <= reg_wdata[3*FIELD_W-1:0];
      if (reg_rd) reg_rdata <= {{FIELD_W{1'b0}}, cfg_q};
    end
  end
endmodule

// File: rtl/arb_raise_timer.sv
module arb_raise_timer #(
  parameter int FIELD_W     = 8,
  parameter int PRESCALE_SH = 4,
  parameter logic [FIELD_W-1:0] INIT = '1,
  localparam int CNT_W = FIELD_W + PRESCALE_SH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] setting,
  input  logic [FIELD_W-1:0] new_setting,
  input  logic               load,
  input  logic               eligible,
  input  logic               consume,
  output logic               raise
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload = {setting, {PRESCALE_SH{1'b0}}};
  assign raise  = eligible && (cnt_q == '0) && (setting != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= {INIT, {PRESCALE_SH{1'b0}}};
    end else if (load) begin
      cnt_q <= {new_setting, {PRESCALE_SH{1'b0}}};
    end else if (!eligible) begin
      cnt_q <= reload;
    end else if (cnt_q == '0) begin
      if (consume) cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/arb_slot_queue.sv
module arb_slot_queue #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enq_valid,
  input  logic                         enq_cls,
  input  logic [DEPTH-1:0]             release_mask,
  output logic                         enq_ready,
  output logic [DEPTH-1:0]             valid_q,
  output logic [DEPTH-1:0]             cls_q,
  output logic [DEPTH-1:0][DEPTH-1:0]  older_q
);
  logic [DEPTH-1:0] ins_mask;
  logic             take;

  assign enq_ready = ~&valid_q;
  assign take      = enq_valid && enq_ready;

  always_comb begin
    ins_mask = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) ins_mask = DEPTH'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      cls_q   <= '0;
      older_q <= '0;
    end else begin
      valid_q <= (valid_q & ~release_mask) | (take ? ins_mask : '0);
      for (int k = 0; k < DEPTH; k++) begin
        if (take && ins_mask[k]) begin
          cls_q[k] <= enq_cls;
          for (int j = 0; j < DEPTH; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= valid_q[j];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmd_age_arbiter.sv
module cmd_age_arbiter #(
  parameter int DEPTH       = 8,
  parameter int FIELD_W     = 8,
  parameter int PRESCALE_SH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int REG_W = 4 * FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  input  logic             enq_cls,
  output logic             enq_ready,
  input  logic             deq_ready,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata
);
  import cmd_arb_pkg::*;

  logic [2:0][FIELD_W-1:0]     fld_cur;
  logic [2:0][FIELD_W-1:0]     fld_new;
  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0]            cls_q;
  logic [DEPTH-1:0][DEPTH-1:0] older_q;
  logic [DEPTH-1:0]            mask_c1, mask_c2;
  logic [DEPTH-1:0]            win_mask, release_mask;
  logic [N_TIMERS-1:0]         elig, cons, raise;
  logic                        fire;
  logic [IDX_W-1:0]            win_idx;

  function automatic logic [DEPTH-1:0] pick_oldest(
    input logic [DEPTH-1:0]            m,
    input logic [DEPTH-1:0][DEPTH-1:0] age
  );
    logic [DEPTH-1:0] sel;
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (m[j] && age[j][i]) blocked = 1'b1;
      end
      sel[i] = m[i] && !blocked;
    end
    return sel;
  endfunction

  arb_cfg_regs #(.FIELD_W(FIELD_W)) u_cfg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .fld_cur(fld_cur), .fld_new(fld_new)
  );

  arb_slot_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_cls(enq_cls),
    .release_mask(release_mask), .enq_ready(enq_ready),
    .valid_q(valid_q), .cls_q(cls_q), .older_q(older_q)
  );

  assign mask_c1 = valid_q & ~cls_q;
  assign mask_c2 = valid_q & cls_q;
  assign elig[T_OLD] = |valid_q;
  assign elig[T_C1]  = |mask_c1;
  assign elig[T_C2]  = |mask_c2;

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
    arb_raise_timer #(
      .FIELD_W(FIELD_W), .PRESCALE_SH(PRESCALE_SH),
      .INIT(FIELD_W'(FIELD_RST))
    ) u_tmr (
      .clk(clk), .rst(rst), .setting(fld_cur[g]), .new_setting(fld_new[g]),
      .load(reg_wr), .eligible(elig[g]), .consume(cons[g]), .raise(raise[g])
    );
  end

  assign fire = deq_ready && (|valid_q);

  always_comb begin
    cons = '0;
    if (raise[T_OLD]) begin
      win_mask    = pick_oldest(valid_q, older_q);
      cons[T_OLD] = fire;
    end else if (raise[T_C1]) begin
      win_mask    = pick_oldest(mask_c1, older_q);
      cons[T_C1]  = fire;
    end else if (raise[T_C2]) begin
      win_mask    = pick_oldest(mask_c2, older_q);
      cons[T_C2]  = fire;
    end else if (|mask_c1) begin
      win_mask    = pick_oldest(mask_c1, older_q);
    end else begin
      win_mask    = pick_oldest(mask_c2, older_q);
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (win_mask[i]) win_idx = win_idx | IDX_W'(i);
    end
  end

  assign release_mask = fire ? win_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
    end else begin
      grant_valid <= fire;
      if (fire) grant_idx <= win_idx;
    end
  end
endmodule

// File: rtl/cmd_age_arbiter_chk.sv
module cmd_age_arbiter_chk #(
  parameter int DEPTH   = 8,
  parameter int IDX_W   = 3,
  parameter int FIELD_W = 8,
  parameter int REG_W   = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enq_valid,
  input logic                    enq_ready,
  input logic                    deq_ready,
  input logic                    grant_valid,
  input logic [IDX_W-1:0]        grant_idx,
  input logic [REG_W-1:0]        reg_rdata,
  input logic [DEPTH-1:0]        valid_q,
  input logic [2:0][FIELD_W-1:0] fld_cur
);
  logic [DEPTH-1:0] prev_valid;

  always_ff @(posedge clk) begin
    if (rst) prev_valid <= '0;
    else     prev_valid <= valid_q;
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:3*FIELD_W] == '0);

  p_reset_cfg_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fld_cur == {3{{FIELD_W{1'b1}}}}));

  p_grant_needs_ready_r10: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> $past(deq_ready));

  p_grant_from_pending_r10: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (prev_valid[grant_idx] && !valid_q[grant_idx]));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && !enq_ready) |=> ($countones(valid_q) <= $past($countones(valid_q))));
endmodule

bind cmd_age_arbiter cmd_age_arbiter_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .FIELD_W(FIELD_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .deq_ready(deq_ready), .grant_valid(grant_valid), .grant_idx(grant_idx),
  .reg_rdata(reg_rdata), .valid_q(valid_q), .fld_cur(fld_cur)
);

// File: tb/cmd_age_arbiter_test.sv
`timescale 1ns/1ps
module cmd_age_arbiter_test;
  logic        clk = 1'b0;
  logic        rst, enq_valid, enq_cls, deq_ready, reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic        enq_ready, grant_valid;
  logic [2:0]  grant_idx;
  logic [31:0] reg_rdata;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  localparam int C1 = 0;
  localparam int C2 = 1;

  // {write value, expected read value}
  localparam logic [63:0] VEC [4] = '{
    {32'h12345678, 32'h00345678},
    {32'hFFFFFFFF, 32'h00FFFFFF},
    {32'h00000000, 32'h00000000},
    {32'hA5015A3C, 32'h00015A3C}
  };

  always #2 clk = ~clk;

  cmd_age_arbiter uut (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_cls(enq_cls),
    .enq_ready(enq_ready), .deq_ready(deq_ready), .grant_valid(grant_valid),
    .grant_idx(grant_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; enq_valid = 1'b0; enq_cls = 1'b0; deq_ready = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    wait_cyc(2);
    rst = 1'b0;
  endtask

  task automatic enq(input int c);
    enq_valid = 1'b1; enq_cls = c[0];
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic grant_step(input int exp, input string req);
    deq_ready = 1'b1;
    @(negedge clk);
    chk(grant_valid && grant_idx == exp[2:0], req, {28'd0, grant_valid, grant_idx}, {28'd0, 1'b1, exp[2:0]});
  endtask

  task automatic grant_stop();
    deq_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R3 reset state
    chk(enq_ready == 1'b1, "R3 enq_ready", {31'd0, enq_ready}, 32'd1);
    chk(grant_valid == 1'b0, "R3 grant_valid", {31'd0, grant_valid}, 32'd0);
    rd(d);
    chk(d == 32'h00FFFFFF, "R3 cfg reset", d, 32'h00FFFFFF);

    // R1 / R2 register table
    for (int v = 0; v < 4; v++) begin
      wr(VEC[v][63:32]);
      rd(d);
      chk(d == VEC[v][31:0], "R1 R2 readback", d, VEC[v][31:0]);
    end

    // R4 default ordering, R10 slot allocation and release
    do_reset();
    enq(C2); enq(C1); enq(C2); enq(C1);
    grant_step(1, "R4 class1 first");
    grant_step(3, "R4 class1 second");
    grant_step(0, "R4 class2 oldest");
    grant_step(2, "R4 class2 last");
    grant_stop();
    @(negedge clk);
    chk(grant_valid == 1'b0, "R10 no grant when empty", {31'd0, grant_valid}, 32'd0);
    enq(C2);
    grant_step(0, "R10 lowest free slot reused");
    grant_stop();

    // R10 full pool, dropped enqueue, age order within class
    do_reset();
    for (int i = 0; i < 8; i++) enq(C1);
    chk(enq_ready == 1'b0, "R10 full", {31'd0, enq_ready}, 32'd0);
    enq(C2);
    for (int i = 0; i < 8; i++) grant_step(i, "R10 drain in arrival order");
    @(negedge clk);
    chk(grant_valid == 1'b0, "R10 dropped enqueue not stored", {31'd0, grant_valid}, 32'd0);
    grant_stop();

    // R6 oldest promotion
    do_reset();
    wr(32'h00000001);
    enq(C2); enq(C1);
    wait_cyc(30);
    grant_step(0, "R6 oldest raised");
    grant_stop();

    // R5 not yet expired at setting 2
    do_reset();
    wr(32'h00000002);
    enq(C2); enq(C1);
    wait_cyc(10);
    grant_step(1, "R5 before expiry");
    grant_stop();

    // R5 write reloads an expired timer
    do_reset();
    wr(32'h00000001);
    enq(C2); enq(C1);
    wait_cyc(30);
    wr(32'h00000002);
    wait_cyc(5);
    grant_step(1, "R5 write reloads");
    grant_stop();

    // R9 zero disables
    do_reset();
    wr(32'h00000000);
    enq(C2); enq(C1);
    wait_cyc(40);
    grant_step(1, "R9 disabled timers");
    grant_stop();

    // R7 class 2 promotion over waiting class 1
    do_reset();
    wr(32'h00000100);
    enq(C1); enq(C2);
    wait_cyc(30);
    grant_step(1, "R7 class2 raised");
    grant_stop();

    // R11 class 2 timer holds while no class 2 is waiting
    do_reset();
    wr(32'h00000100);
    enq(C1);
    wait_cyc(40);
    enq(C2);
    wait_cyc(3);
    grant_step(0, "R11 timer held");
    grant_stop();

    // R8 all promotions at once, R7 class 1 promotion
    do_reset();
    wr(32'h00010101);
    enq(C2); enq(C1); enq(C2); enq(C1);
    wait_cyc(30);
    grant_step(0, "R8 oldest ranks first");
    grant_step(1, "R7 R8 class1 raise next");
    grant_step(2, "R8 class2 raise kept");
    grant_step(3, "R8 normal order resumes");
    grant_stop();

    wait_cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule